// File: doc/BRIEF.md
# DAC SPI Bring-Up Sequencer

This block drives a dual-channel 16-bit DAC over a write-only SPI link. A single start pulse launches a fixed bring-up series of register writes. An optional write turns off the on-chip reference. A second write sets the reference halving and the output gain. Two more writes load the power-up codes for channel A and channel B. The two option inputs are captured when start is accepted, so they may change while the series runs.

When the last bring-up write has finished, the block pulses `done` for one cycle. From then on it serves a valid/ready host port. Each accepted 24-bit word is sent verbatim as one SPI packet. The serial clock is the system clock divided by a parameter. Chip select is framed around each packet separately, with guard time on both sides of the clock burst and an idle gap between packets.

Top module: `dac_boot_spi_seq`

## Requirements
- R1: SPI mode 1. `sclk` idles low. `mosi` changes only on a rising `sclk` edge or when `cs_n` releases. The receiver samples `mosi` on the falling edge.
- R2: `cs_n` goes low for exactly one 24-bit packet and then returns high. `sclk` is low whenever `cs_n` is high. `cs_n` stays high for at least GAP_HALVES*HALF_DIV clocks (8 by default) between packets.
- R3: Each packet is sent MSB first. Bits 23:20 are zero (write), bits 19:16 hold the register address, and bits 15:0 hold the data.
- R4: Each `sclk` half period lasts HALF_DIV clocks. `cs_n` falls exactly HALF_DIV clocks before the first rising edge. It rises exactly HALF_DIV clocks after the last falling edge.
- R5: With `ext_ref`=1 at start, the first packet is 0x030100, which turns off the on-chip reference.
- R6: With `ext_ref`=0 at start, that packet is skipped, and the series opens with the gain packet.
- R7: The gain packet targets address 0x4 with data {7'b0, ref_half, 6'b0, 2'b11}. This gives 0x040103 when halving and 0x040003 when not. Both options are latched at the start pulse.
- R8: The series ends with 0x087FFF (channel A, mid-scale) and then 0x09FFFF (channel B, full-scale), in that order.
- R9: `busy` rises in the cycle after start is accepted. It stays high for N*(1+53*HALF_DIV) cycles, plus 1 when the first step is skipped, where N is the number of packets sent. `done` is high for the single cycle in which `busy` first reads low. `cs_n` falls 2 cycles after the start edge, or 3 when the first step is skipped.
- R10: `host_ready` stays low until the first `done` and whenever a packet or the bring-up is in progress. A word accepted with `host_valid`&&`host_ready` is sent unchanged, with `cs_n` low one cycle after the accepting edge.
- R11: A start pulse while `busy` is high is ignored. No extra packets are sent and `busy` timing is unchanged.
- R12: Reset (`rst_n` low) gives `cs_n`=1, `sclk`=0, `mosi`=0, `busy`=0, `done`=0 and `host_ready`=0, and aborts any packet in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that launches the bring-up series |
| ext_ref | input | 1 | 1: external reference, so the on-chip one is turned off |
| ref_half | input | 1 | 1: request reference halving in the gain packet |
| host_valid | input | 1 | Host word available |
| host_frame | input | 24 | Host word, sent verbatim |
| host_ready | output | 1 | Host word accepted this cycle when valid |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI serial data out |
| cs_n | output | 1 | SPI chip select, active low |
| busy | output | 1 | Bring-up series in progress |
| done | output | 1 | One-cycle pulse when the series ends |

## Verification
From the start edge, `busy` is due one cycle later and `cs_n` two or three cycles later. `done` is due in the cycle that ends the N*(1+53*HALF_DIV)-cycle window. The bench loads that count into a down-counter right after the start edge and compares `busy` and `done` against it on every clock. A host word's packet opens one cycle after its accepting edge. Inside a packet, each clock edge is due HALF_DIV cycles after the previous event. The bench measures these distances in cycles from a per-clock monitor and compares each completed packet with the head of an expected queue. All outputs are sampled on the falling system-clock edge, half a cycle after the registers that drive them update.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

   localparam int unsigned FRAME_W = 24;
   localparam int unsigned DATA_W  = 16;
   localparam int unsigned ADDR_W  = 4;
   localparam int unsigned N_STEPS = 4;
   localparam int unsigned STEP_W  = $clog2(N_STEPS);

   typedef logic [FRAME_W-1:0] frame_t;

   localparam logic [ADDR_W-1:0] REG_REFCTL = 4'h3;
   localparam logic [ADDR_W-1:0] REG_SCALE  = 4'h4;
   localparam logic [ADDR_W-1:0] REG_CHAN_A = 4'h8;
   localparam logic [ADDR_W-1:0] REG_CHAN_B = 4'h9;
   localparam logic [DATA_W-1:0] REFCTL_OFF = 16'h0100;

   typedef enum logic [2:0] {
      TX_IDLE,
      TX_LEAD,
      TX_SHIFT,
      TX_TRAIL,
      TX_GAP
   } tx_state_t;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_ISSUE,
      SQ_WAIT,
      SQ_HOST
   } sq_state_t;

   function automatic frame_t pack_write(input logic [ADDR_W-1:0] addr,
                                         input logic [DATA_W-1:0] val);
      return {4'h0, addr, val};
   endfunction

endpackage

// File: rtl/dacseq_half_tick.sv
module dacseq_half_tick #(
   parameter int unsigned HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("dacseq_half_tick: HALF_DIV must be at least 1");
      end

      if (HALF_DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int unsigned CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!run || cnt == LAST)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         assign tick = run && (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/dacseq_spi_tx.sv
module dacseq_spi_tx
   import dacseq_pkg::*;
#(
   parameter int unsigned HALF_DIV   = 2,
   parameter int unsigned GAP_HALVES = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load,
   input  frame_t frame,
   output logic   ready,
   output logic   frame_end,
   output logic   sclk,
   output logic   mosi,
   output logic   cs_n
);

   localparam int unsigned BW = $clog2(FRAME_W);
   localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);
   localparam int unsigned GW = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;
   localparam logic [GW-1:0] LAST_GAP = GW'(GAP_HALVES - 1);

   generate
      if (GAP_HALVES < 4) begin : g_bad_gap
         $error("dacseq_spi_tx: GAP_HALVES below two serial clock periods");
      end
   endgenerate

   tx_state_t       st;
   frame_t          sh;
   logic [BW-1:0]   bitcnt;
   logic [GW-1:0]   gapcnt;
   logic            tick;

   dacseq_half_tick #(.HALF_DIV(HALF_DIV)) i_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st != TX_IDLE),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= TX_IDLE;
         sh     <= '0;
         bitcnt <= '0;
         gapcnt <= '0;
         sclk   <= 1'b0;
         mosi   <= 1'b0;
         cs_n   <= 1'b1;
      end else begin
         case (st)
            TX_IDLE: begin
               if (load) begin
                  sh     <= frame;
                  bitcnt <= '0;
                  cs_n   <= 1'b0;
                  st     <= TX_LEAD;
               end
            end
            TX_LEAD: begin
               if (tick) begin
                  sclk <= 1'b1;
                  mosi <= sh[FRAME_W-1];
                  sh   <= {sh[FRAME_W-2:0], 1'b0};
                  st   <= TX_SHIFT;
               end
            end
            TX_SHIFT: begin
               if (tick) begin
                  if (sclk) begin
                     sclk <= 1'b0;
                     if (bitcnt == LAST_BIT)
                        st <= TX_TRAIL;
                     else
                        bitcnt <= bitcnt + 1'b1;
                  end else begin
                     sclk <= 1'b1;
                     mosi <= sh[FRAME_W-1];
                     sh   <= {sh[FRAME_W-2:0], 1'b0};
                  end
               end
            end
            TX_TRAIL: begin
               if (tick) begin
                  cs_n   <= 1'b1;
                  mosi   <= 1'b0;
                  gapcnt <= '0;
                  st     <= TX_GAP;
               end
            end
            TX_GAP: begin
               if (tick) begin
                  if (gapcnt == LAST_GAP)
                     st <= TX_IDLE;
                  else
                     gapcnt <= gapcnt + 1'b1;
               end
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   assign ready     = (st == TX_IDLE);
   assign frame_end = (st == TX_GAP) && tick && (gapcnt == LAST_GAP);

   // R2: the serial clock rests low outside a packet
   a_r2_clock_rests_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R1: data moves only on a rising clock edge or on select release
   a_r1_launch_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!$rose(sclk) && !$rose(cs_n)) |-> $stable(mosi));

   // R4: select never falls together with the first rising clock edge
   a_r4_lead_guard: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> !$fell(cs_n));

   // R4: select never rises together with the last falling clock edge
   a_r4_trail_guard: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> !$fell(sclk));

   // R2: a new packet is never loaded while one is in progress
   a_r2_one_packet: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !ready) |=> !$fell(cs_n));

endmodule

// File: rtl/dacseq_step_table.sv
module dacseq_step_table
   import dacseq_pkg::*;
#(
   parameter logic [DATA_W-1:0] INIT_A   = 16'h7FFF,
   parameter logic [DATA_W-1:0] INIT_B   = 16'hFFFF,
   parameter logic [1:0]        GAIN_SEL = 2'b11
) (
   input  logic [STEP_W-1:0] idx,
   input  logic              ext_ref,
   input  logic              ref_half,
   output frame_t            frame,
   output logic              apply
);

   always_comb begin
      apply = 1'b1;
      frame = '0;
      case (idx)
         2'd0: begin
            apply = ext_ref;
            frame = pack_write(REG_REFCTL, REFCTL_OFF);
         end
         2'd1:    frame = pack_write(REG_SCALE, {7'd0, ref_half, 6'd0, GAIN_SEL});
         2'd2:    frame = pack_write(REG_CHAN_A, INIT_A);
         default: frame = pack_write(REG_CHAN_B, INIT_B);
      endcase
   end

endmodule

// File: rtl/dac_boot_spi_seq.sv
module dac_boot_spi_seq
   import dacseq_pkg::*;
#(
   parameter int unsigned       HALF_DIV   = 2,
   parameter int unsigned       GAP_HALVES = 4,
   parameter logic [DATA_W-1:0] INIT_A     = 16'h7FFF,
   parameter logic [DATA_W-1:0] INIT_B     = 16'hFFFF,
   parameter logic [1:0]        GAIN_SEL   = 2'b11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               ext_ref,
   input  logic               ref_half,
   input  logic               host_valid,
   input  logic [FRAME_W-1:0] host_frame,
   output logic               host_ready,
   output logic               sclk,
   output logic               mosi,
   output logic               cs_n,
   output logic               busy,
   output logic               done
);

   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

   sq_state_t         sq;
   logic [STEP_W-1:0] idx;
   logic              ext_q;
   logic              half_q;
   frame_t            step_frame;
   logic              step_apply;
   logic              tx_ready;
   logic              tx_end;
   logic              tx_load;
   frame_t            tx_frame;
   logic              start_ok;
   logic              issue_load;
   logic              host_fire;

   dacseq_step_table #(
      .INIT_A   (INIT_A),
      .INIT_B   (INIT_B),
      .GAIN_SEL (GAIN_SEL)
   ) i_table (
      .idx      (idx),
      .ext_ref  (ext_q),
      .ref_half (half_q),
      .frame    (step_frame),
      .apply    (step_apply)
   );

   dacseq_spi_tx #(
      .HALF_DIV   (HALF_DIV),
      .GAP_HALVES (GAP_HALVES)
   ) i_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tx_load),
      .frame     (tx_frame),
      .ready     (tx_ready),
      .frame_end (tx_end),
      .sclk      (sclk),
      .mosi      (mosi),
      .cs_n      (cs_n)
   );

   assign busy       = (sq == SQ_ISSUE) || (sq == SQ_WAIT);
   assign start_ok   = start && tx_ready && ((sq == SQ_IDLE) || (sq == SQ_HOST));
   assign host_ready = (sq == SQ_HOST) && tx_ready && !start;
   assign host_fire  = host_valid && host_ready;
   assign issue_load = (sq == SQ_ISSUE) && step_apply;
   assign tx_load    = issue_load || host_fire;
   assign tx_frame   = issue_load ? step_frame : host_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq     <= SQ_IDLE;
         idx    <= '0;
         ext_q  <= 1'b0;
         half_q <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (sq)
            SQ_IDLE, SQ_HOST: begin
               if (start_ok) begin
                  ext_q  <= ext_ref;
                  half_q <= ref_half;
                  idx    <= '0;
                  sq     <= SQ_ISSUE;
               end
            end
            SQ_ISSUE: begin
               if (step_apply)
                  sq <= SQ_WAIT;
               else
                  idx <= idx + 1'b1;
            end
            SQ_WAIT: begin
               if (tx_end) begin
                  if (idx == LAST_STEP) begin
                     done <= 1'b1;
                     sq   <= SQ_HOST;
                  end else begin
                     idx <= idx + 1'b1;
                     sq  <= SQ_ISSUE;
                  end
               end
            end
            default: sq <= SQ_IDLE;
         endcase
      end
   end

   // R9: done lasts one cycle
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: done marks the cycle busy drops
   a_r9_done_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $fell(busy));

   // R10: the host port is closed during the bring-up series
   a_r10_host_closed: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> (!busy && cs_n));

   // R11: a start pulse mid-series leaves busy high
   a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (sq == SQ_WAIT) && !tx_end) |=> busy);

   // R8: the series only ends after the last step's packet
   a_r8_ends_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(idx == LAST_STEP));

endmodule

// File: tb/test_dac_boot_spi_seq.sv
module test_dac_boot_spi_seq;

   localparam int H   = 2;
   localparam int GAP = 4;
   localparam int PKT = 1 + 53 * H;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        ext_ref = 1'b0;
   logic        ref_half = 1'b0;
   logic        host_valid = 1'b0;
   logic [23:0] host_frame = '0;
   logic        host_ready, sclk, mosi, cs_n, busy, done;

   dac_boot_spi_seq #(.HALF_DIV(H), .GAP_HALVES(GAP)) i_dac_boot_spi_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .ext_ref(ext_ref),
      .ref_half(ref_half), .host_valid(host_valid), .host_frame(host_frame),
      .host_ready(host_ready), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
      .busy(busy), .done(done)
   );

   always #4 clk = ~clk;

   int n_checks = 0;
   int n_err = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // reference model state
   logic [23:0] exp_q[$];
   string       tag_q[$];
   int          busy_left = 0;
   logic        done_due = 1'b0;
   int          model_err = 0;

   // protocol monitor state
   int          cyc = 0;
   logic        p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b0;
   int          t_csfall = 0, t_csrise = -1000, t_edge = 0;
   logic        in_frame = 1'b0, first_rise = 1'b0;
   int          nbits = 0;
   logic [23:0] cap = '0;
   int          idle_err = 0, mosi_err = 0, gap_err = 0;
   int          lead_err = 0, half_err = 0, hr_err = 0;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         in_frame = 1'b0; p_cs = 1'b1; p_sclk = 1'b0; p_mosi = 1'b0;
         t_csrise = -1000; busy_left = 0; done_due = 1'b0;
      end else begin
         if (busy !== (busy_left > 0) || done !== done_due) model_err++;
         done_due = (busy_left == 1);
         if (busy_left > 0) busy_left--;

         if (cs_n && sclk) idle_err++;
         if (host_ready && busy) hr_err++;
         if (mosi !== p_mosi && !(sclk && !p_sclk) && !(cs_n && !p_cs)) mosi_err++;
         if (!cs_n && p_cs) begin
            if (cyc - t_csrise < GAP * H) gap_err++;
            t_csfall = cyc; nbits = 0; cap = '0; in_frame = 1'b1; first_rise = 1'b1;
         end
         if (sclk && !p_sclk) begin
            if (first_rise) begin
               if (cyc - t_csfall != H) lead_err++;
               first_rise = 1'b0;
            end else if (cyc - t_edge != H) half_err++;
            t_edge = cyc;
         end
         if (!sclk && p_sclk) begin
            if (cyc - t_edge != H) half_err++;
            t_edge = cyc;
            cap = {cap[22:0], mosi};
            nbits++;
         end
         if (cs_n && !p_cs && in_frame) begin
            if (cyc - t_edge != H) lead_err++;
            t_csrise = cyc; in_frame = 1'b0;
            chk("R2 bits per packet", nbits, 24);
            if (exp_q.size() == 0)
               chk("R3 unexpected packet", cap, 24'hFFFFFF ^ cap);
            else
               chk(tag_q.pop_front(), cap, exp_q.pop_front());
         end
         p_cs = cs_n; p_sclk = sclk; p_mosi = mosi;
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++; n_checks++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      finish_run();
   end

   task automatic push(input logic [23:0] f, input string tag);
      exp_q.push_back(f);
      tag_q.push_back(tag);
   endtask

   task automatic kick(input logic e, input logic h, input int n_busy);
      @(posedge clk) #1;
      ext_ref = e; ref_half = h; start = 1'b1;
      @(posedge clk) #1;
      start = 1'b0; ext_ref = ~e; ref_half = ~h;   // R7: options latched
      busy_left = n_busy;
   endtask

   task automatic run_init(input logic e, input logic h);
      int lat;
      if (e) push(24'h030100, "R5 reference-off packet");
      push(h ? 24'h040103 : 24'h040003, "R7 gain packet");
      push(24'h087FFF, "R8 channel A packet");
      push(24'h09FFFF, "R8 channel B packet");
      kick(e, h, (e ? 4 : 3) * PKT + (e ? 0 : 1));
      lat = 0;
      do begin @(negedge clk); lat++; end while (cs_n);
      chk(e ? "R9 start-to-select latency" : "R6 skipped step latency", lat, e ? 2 : 3);
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done);
      @(negedge clk);
   endtask

   task automatic host_send(input logic [23:0] f);
      int lat;
      push(f, "R10 host packet");
      @(posedge clk) #1;
      host_valid = 1'b1; host_frame = f;
      do @(negedge clk); while (!host_ready);
      @(posedge clk) #1;
      host_valid = 1'b0;
      lat = 0;
      do begin @(negedge clk); lat++; end while (cs_n);
      chk("R10 accept-to-select latency", lat, 1);
      do @(negedge clk); while (!cs_n);
   endtask

   initial begin
      int low_cnt, rdy_cnt;
      // R12: reset state
      repeat (4) @(negedge clk);
      chk("R12 cs_n in reset", cs_n, 1);
      chk("R12 sclk in reset", sclk, 0);
      chk("R12 mosi in reset", mosi, 0);
      chk("R12 busy in reset", busy, 0);
      chk("R12 done in reset", done, 0);
      @(posedge clk) #1 rst_n = 1'b1;

      // R10: host port closed before bring-up
      @(posedge clk) #1;
      host_valid = 1'b1; host_frame = 24'h0A1234;
      low_cnt = 0; rdy_cnt = 0;
      repeat (20) begin
         @(negedge clk);
         if (!cs_n) low_cnt++;
         if (host_ready) rdy_cnt++;
      end
      @(posedge clk) #1 host_valid = 1'b0;
      chk("R10 host_ready before bring-up", rdy_cnt, 0);
      chk("R10 no packet before bring-up", low_cnt, 0);

      // R6/R7: internal reference, no halving
      run_init(1'b0, 1'b0);
      wait_done();
      chk("R8 internal-ref series complete", exp_q.size(), 0);

      // R5/R7/R11: external reference with halving, extra start mid-series
      run_init(1'b1, 1'b1);
      repeat (150) @(negedge clk);
      @(posedge clk) #1; start = 1'b1; ext_ref = 1'b0;
      @(posedge clk) #1; start = 1'b0;
      @(negedge clk);
      chk("R11 busy held after ignored start", busy, 1);
      wait_done();
      chk("R11 no extra packets", exp_q.size(), 0);

      // R10: host writes after done
      host_send(24'h0A1234);
      host_send(24'h0B5678);
      repeat (12) @(negedge clk);
      chk("R10 host packets complete", exp_q.size(), 0);

      // R12: reset aborts a packet in progress
      kick(1'b1, 1'b0, 4 * PKT);
      repeat (40) @(negedge clk);
      @(posedge clk) #1 rst_n = 1'b0;
      exp_q.delete(); tag_q.delete();
      @(negedge clk);
      chk("R12 cs_n after mid-packet reset", cs_n, 1);
      chk("R12 sclk after mid-packet reset", sclk, 0);
      chk("R12 busy after mid-packet reset", busy, 0);
      @(posedge clk) #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R12 host port closed after reset", host_ready, 0);
      chk("R12 stays idle after reset", cs_n, 1);

      chk("R1 mosi moved off a rising edge", mosi_err, 0);
      chk("R2 clock high while deselected", idle_err, 0);
      chk("R2 inter-packet gap too short", gap_err, 0);
      chk("R4 lead or trail guard", lead_err, 0);
      chk("R4 half-period length", half_err, 0);
      chk("R9 busy/done cycle model", model_err, 0);
      chk("R10 host_ready while busy", hr_err, 0);
      finish_run();
   end

endmodule